// File: doc/BRIEF.md
# Non-revertive reference autoswitch controller

This controller decides which of two reference clock inputs is routed to a phase detector. With the automatic mode control low, a select pin picks the input directly. Raising the mode control arms a one-shot automatic fallback. If the loss flag of the routed input then goes high, the controller moves to the other input once. It stays there until the mode control is dropped again.

Both control pins are asynchronous to the control clock and pass through synchronizer chains before use. The loss flag belongs to the routed input and is taken as already synchronous to the control clock. The outputs are the mux select, an acknowledge that mirrors the routed input, and a one-cycle event on every selection change. That event is intended to start phase build-out logic elsewhere.

Top module: `ref_autoswitch`

## Requirements
- R1: While the synchronized mode control is low, the selection equals the synchronized select pin (1 routes input 1, 0 routes input 0), and the loss flag has no effect on it.
- R2: When armed with no switch made yet, a high loss flag moves the selection to the other input on the next clock edge.
- R3: At most one automatic switch is made per arming, and the selection never returns even if the new input is also dead. The loss flag then stays high.
- R4: After an automatic switch, and until the mode control goes low, changes on the select pin do not affect the selection.
- R5: Arming happens only on a low-to-high transition of the synchronized mode control, and the selection still equals the select pin at that moment. While armed and before a switch, the selection keeps following the select pin.
- R6: The acknowledge output always equals the routed input: 1 for input 1, 0 for input 0.
- R7: The reselection event is high for exactly one cycle: the first cycle in which a new selection is driven, whatever caused the change. It is low in every other cycle.
- R8: After reset the controller is in manual mode and disarmed, with selection, acknowledge and event all 0.
- R9: A select pin change reaches the selection on the (SYNC_STAGES+1)-th rising clock edge after the change, which is the third edge with the default of 2 stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_mode_i | input | 1 | Mode control, asynchronous: 1 = automatic, 0 = manual |
| ref_sel_i | input | 1 | Select pin, asynchronous: 1 = input 1, 0 = input 0 |
| sel_lost_i | input | 1 | Loss-of-activity flag of the currently routed input |
| mux_sel_o | output | 1 | Select driving the reference mux |
| ref_ack_o | output | 1 | Acknowledge of the routed input |
| reselect_o | output | 1 | One-cycle pulse on every selection change |

## Verification
The bench goes after the one-shot nature of the fallback. It kills the fallback input after a switch, so a controller that wrongly reverts would bounce back and emit extra events. It toggles the select pin after a switch and while armed, which catches a controller that either lets the pin override a switch or freezes the pin before any fault. It also kills input 0 while in manual mode, where a design that ignored the mode would switch. Re-arming is exercised through the low-then-high sequence, and the synchronizer latency is checked edge by edge, which exposes a missing or extra stage.

// File: rtl/ref_autoswitch.sv
module ref_autoswitch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_mode_i,
  input  logic ref_sel_i,
  input  logic sel_lost_i,
  output logic mux_sel_o,
  output logic ref_ack_o,
  output logic reselect_o
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] auto_sync, rsel_sync;
  logic auto_s, rsel_s, auto_prev;
  logic armed_q, tripped_q, sel_q, pulse_q;
  logic armed_n, tripped_n, sel_n;

  assign auto_s = auto_sync[TOP];
  assign rsel_s = rsel_sync[TOP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_sync <= '0;
      rsel_sync <= '0;
      auto_prev <= 1'b0;
    end else begin
      auto_sync <= {auto_sync[TOP-1:0], auto_mode_i};
      rsel_sync <= {rsel_sync[TOP-1:0], ref_sel_i};
      auto_prev <= auto_s;
    end
  end

  always_comb begin
    sel_n     = sel_q;
    armed_n   = armed_q;
    tripped_n = tripped_q;
    if (!auto_s) begin
      sel_n     = rsel_s;
      armed_n   = 1'b0;
      tripped_n = 1'b0;
    end else if (!auto_prev) begin
      sel_n     = rsel_s;
      armed_n   = 1'b1;
      tripped_n = 1'b0;
    end else if (armed_q && sel_lost_i) begin
      sel_n     = ~sel_q;
      armed_n   = 1'b0;
      tripped_n = 1'b1;
    end else if (!tripped_q) begin
      sel_n = rsel_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      tripped_q <= 1'b0;
      sel_q     <= 1'b0;
      pulse_q   <= 1'b0;
    end else begin
      armed_q   <= armed_n;
      tripped_q <= tripped_n;
      sel_q     <= sel_n;
      pulse_q   <= sel_n ^ sel_q;
    end
  end

  assign mux_sel_o  = sel_q;
  assign ref_ack_o  = sel_q;
  assign reselect_o = pulse_q;

endmodule

// File: rtl/ref_autoswitch_chk.sv
module ref_autoswitch_chk (
  input logic clk,
  input logic rst_n,
  input logic sel_lost_i,
  input logic mux_sel_o,
  input logic reselect_o,
  input logic auto_s,
  input logic rsel_s,
  input logic tripped
);

  assert_manual_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_s |=> mux_sel_o == $past(rsel_s));

  assert_trip_needs_loss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tripped) |-> $past(sel_lost_i));

  assert_single_switch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tripped && $past(tripped)) |-> $stable(mux_sel_o));

  assert_event_on_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_sel_o != $past(mux_sel_o)) |-> reselect_o);

  assert_event_only_on_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reselect_o |-> (mux_sel_o != $past(mux_sel_o)));

endmodule

bind ref_autoswitch ref_autoswitch_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_lost_i (sel_lost_i),
  .mux_sel_o  (mux_sel_o),
  .reselect_o (reselect_o),
  .auto_s     (auto_s),
  .rsel_s     (rsel_s),
  .tripped    (tripped_q)
);

// File: tb/ref_autoswitch_tb_top.sv
module ref_autoswitch_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_mode, ref_sel;
  logic [1:0] dead;
  logic lost, mux_sel, ack, resel;
  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;
  logic exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign lost = dead[mux_sel];

  ref_autoswitch dut_i (
    .clk(clk), .rst_n(rst_n), .auto_mode_i(auto_mode), .ref_sel_i(ref_sel),
    .sel_lost_i(lost), .mux_sel_o(mux_sel), .ref_ack_o(ack), .reselect_o(resel)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_sel(input logic v);
    exp_q.push_back(v);
  endtask

  always @(negedge clk) begin
    if (rst_n && resel) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fails++;
        $display("FAIL R7 actual=unexpected event ack=%0b expected=no event", ack);
      end else begin
        logic e;
        e = exp_q.pop_front();
        if (ack !== e || mux_sel !== e) begin
          n_fails++;
          $display("FAIL R6 actual=%0b expected=%0b", ack, e);
        end
      end
    end
  end

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    auto_mode = 1'b0; ref_sel = 1'b0; dead = 2'b00;
    cyc(3);
    chk(mux_sel, 1'b0, "R8 sel");
    chk(ack, 1'b0, "R8 ack");
    chk(resel, 1'b0, "R8 event");
    rst_n = 1'b1;
    cyc(4);
    chk(ack, 1'b0, "R8 after release");

    // R9 latency and R1 manual select
    expect_sel(1'b1);
    ref_sel = 1'b1;
    cyc(2);
    chk(ack, 1'b0, "R9 two edges");
    cyc(1);
    chk(ack, 1'b1, "R9 third edge");
    chk(resel, 1'b1, "R7 pulse");
    cyc(1);
    chk(resel, 1'b0, "R7 one cycle");
    expect_sel(1'b0);
    ref_sel = 1'b0;
    cyc(6);
    chk(ack, 1'b0, "R1 manual back to 0");

    // R1 loss ignored in manual mode
    dead = 2'b01;
    cyc(6);
    chk(ack, 1'b0, "R1 loss ignored");
    dead = 2'b00;

    // R5 arming keeps selection and pin still drives before a fault
    auto_mode = 1'b1;
    cyc(6);
    chk(ack, 1'b0, "R5 armed keeps 0");
    expect_sel(1'b1);
    ref_sel = 1'b1;
    cyc(6);
    chk(ack, 1'b1, "R5 pin before fault");
    expect_sel(1'b0);
    ref_sel = 1'b0;
    cyc(6);
    chk(ack, 1'b0, "R5 pin back");

    // R2 automatic switch
    expect_sel(1'b1);
    dead = 2'b01;
    cyc(3);
    chk(ack, 1'b1, "R2 switched");
    chk(lost, 1'b0, "R2 new input alive");

    // R4 pin ignored after switch
    ref_sel = 1'b1;
    cyc(6);
    ref_sel = 1'b0;
    cyc(6);
    chk(ack, 1'b1, "R4 pin ignored");

    // R3 no return even if new input dies
    dead = 2'b11;
    cyc(10);
    chk(ack, 1'b1, "R3 no revert");
    chk(lost, 1'b1, "R3 loss stays");

    // R5 re-arm: low then high
    dead = 2'b00;
    ref_sel = 1'b1;
    cyc(6);
    auto_mode = 1'b0;
    cyc(6);
    chk(ack, 1'b1, "R1 manual keeps 1");
    auto_mode = 1'b1;
    cyc(6);
    expect_sel(1'b0);
    dead = 2'b10;
    cyc(3);
    chk(ack, 1'b0, "R5 re-armed switch");

    // R3 landing on a dead input
    dead = 2'b00;
    ref_sel = 1'b0;
    auto_mode = 1'b0;
    cyc(6);
    auto_mode = 1'b1;
    cyc(6);
    expect_sel(1'b1);
    dead = 2'b11;
    cyc(10);
    chk(ack, 1'b1, "R3 dead target ack");
    chk(lost, 1'b1, "R3 dead target loss");

    cyc(4);
    chk(exp_q.size() == 0, 1'b1, "R7 all events seen");
    done = 1'b1;
    summary();
    $finish;
  end
endmodule